// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Masking

The arbiter sits between a processor core and its interrupt sources. Fifteen maskable sources compete for service. Source 0 is the external interrupt pin, and sources 1 to 14 are peripheral request lines. A non-maskable request line outranks all of them. Every request passes through a two-flop synchronizer. The winning request is then captured in a registered grant with a 4-bit vector index. The grant stays fixed until the core acknowledges it.

The block holds two mask bits:

- **I** blocks every maskable source.
- **X** blocks the non-maskable source. Software can clear X but has no way to set it.

When the core acknowledges a grant (interrupt entry), the block sets I. For the non-maskable source it sets both I and X. The return strobe reloads both bits from a restore bus that the core drives.

A promotion register names one maskable source that wins over all other maskable sources. This register can be written only while I is set. The external pin works either as an active-low level request or as a falling-edge request. In edge mode, each falling edge is held in a pending latch until that source is acknowledged.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset: `i_mask`=1, `x_mask`=1, `prio_sel`=0 and `grant_valid`=0.
- R2: With no promotion in effect (`prio_sel`=0), the pending unmasked maskable source with the lowest index wins. The vector equals that index. Index 0 is the external pin, and `periph_req[k]` is index k+1.
- R3: The source named by `prio_sel` wins over every other pending maskable source. When that source is not pending, the order of R2 applies.
- R4: A `prio_wr` write loads `prio_wdata` into `prio_sel` only when `i_mask` is 1 and the value is 14 or less. All other writes leave `prio_sel` unchanged.
- R5: While `i_mask` is 1, no maskable source is granted, but its request stays pending. `set_i` sets `i_mask` and `clr_i` clears it. If both are high in the same cycle, `set_i` wins.
- R6: The grant is registered. `grant_vec` holds its value while `grant_valid` is high, whatever the requests do. An `int_ack` pulse while `grant_valid` is high clears `grant_valid` and sets `i_mask`.
- R7: A synchronized `nmi_req` with `x_mask`=0 is granted with vector 15. It wins over every maskable source and does not depend on `i_mask`. While `x_mask`=1 it is never granted. Acknowledging it sets both `x_mask` and `i_mask`.
- R8: `clr_x` clears `x_mask`. No software input sets it. It becomes 1 only through reset, acknowledgement of vector 15, or the return strobe.
- R9: `int_ret` loads `x_mask` from `ret_x` and `i_mask` from `ret_i`. Its priority is below acknowledgement and above `set_i`, `clr_i` and `clr_x`.
- R10: With `irq_edge_mode`=0, a low `irq_n` is a request for as long as it stays low. After an acknowledgement, a pin that is still low is granted again once `i_mask` clears.
- R11: With `irq_edge_mode`=1, a falling edge on `irq_n` latches a request. The request survives the pin going high again. Acknowledging vector 0 clears the latch, so one edge produces exactly one grant.
- R12: A request that appears on an input is reflected in the grant no later than the fourth clock edge after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | External interrupt pin, active low (source 0) |
| irq_edge_mode | input | 1 | 0: level mode, 1: falling-edge mode for `irq_n` |
| periph_req | input | 14 | Peripheral request lines, bit k is source k+1 |
| nmi_req | input | 1 | Non-maskable request, active high |
| set_i | input | 1 | Software command that sets `i_mask` |
| clr_i | input | 1 | Software command that clears `i_mask` |
| clr_x | input | 1 | Software command that clears `x_mask` |
| int_ack | input | 1 | Interrupt-entry strobe from the core |
| int_ret | input | 1 | Return strobe from the core |
| ret_x | input | 1 | Value of `x_mask` restored on `int_ret` |
| ret_i | input | 1 | Value of `i_mask` restored on `int_ret` |
| prio_wr | input | 1 | Write strobe for the promotion register |
| prio_wdata | input | 4 | Source index to promote |
| grant_valid | output | 1 | A grant is held for the core |
| grant_vec | output | 4 | Granted vector: 0 to 14 maskable, 15 non-maskable |
| i_mask | output | 1 | Maskable-disable bit |
| x_mask | output | 1 | Non-maskable-disable bit |
| prio_sel | output | 4 | Promoted source index |

## Verification
The assertions check, on every cycle, the invariants that hold at each clock edge:

- a held grant never changes its vector;
- a maskable grant is never loaded while I is set, and a non-maskable grant is never loaded while X is set;
- X rises only on a non-maskable acknowledgement or on a return;
- the promotion register changes only on a write made while I is set;
- an acknowledgement always leaves I set and the grant empty.

Only the bench scenarios can show which source wins. These scenarios cover:

- the lowest-index rule over every pair of sources;
- the promoted source for every possible promotion, both while it is pending and after it drops out;
- the one-grant-per-edge behaviour of the pin in edge mode against its repeated grants in level mode;
- the restore values taken on a return.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NSRC = 15,
  parameter int VW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic            irq_edge_mode,
  input  logic [NSRC-2:0] periph_req,
  input  logic            nmi_req,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            clr_x,
  input  logic            int_ack,
  input  logic            int_ret,
  input  logic            ret_x,
  input  logic            ret_i,
  input  logic            prio_wr,
  input  logic [VW-1:0]   prio_wdata,
  output logic            grant_valid,
  output logic [VW-1:0]   grant_vec,
  output logic            i_mask,
  output logic            x_mask,
  output logic [VW-1:0]   prio_sel
);
  localparam int             NRAW    = NSRC + 1;
  localparam int             NSLOT   = 1 << VW;
  localparam logic [VW-1:0]  NMI_VEC = VW'(NSRC);

  logic [NRAW-1:0]  meta_q, sync_q;
  logic             pin_d, edge_pend;
  logic [NSRC-1:0]  mreq;
  logic [NSLOT-1:0] mreq_w;
  logic             nmi_ok, take, cand_valid;
  logic [VW-1:0]    cand;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {nmi_req, periph_req, ~irq_n};
      sync_q <= meta_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_d     <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      pin_d <= sync_q[0];
      if (take && grant_vec == '0)
        edge_pend <= 1'b0;
      else if (irq_edge_mode && sync_q[0] && !pin_d)
        edge_pend <= 1'b1;
    end

  assign take   = int_ack && grant_valid;
  assign nmi_ok = sync_q[NSRC] && !x_mask;
  assign mreq   = {sync_q[NSRC-1:1], irq_edge_mode ? edge_pend : sync_q[0]} & {NSRC{!i_mask}};
  assign mreq_w = NSLOT'(mreq);

  always_comb begin
    cand_valid = 1'b0;
    cand       = '0;
    if (nmi_ok) begin
      cand_valid = 1'b1;
      cand       = NMI_VEC;
    end else if (mreq_w[prio_sel]) begin
      cand_valid = 1'b1;
      cand       = prio_sel;
    end else begin
      for (int k = NSRC - 1; k >= 0; k--)
        if (mreq[k]) begin
          cand_valid = 1'b1;
          cand       = VW'(k);
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_vec   <= '0;
    end else if (take) begin
      grant_valid <= 1'b0;
    end else if (!grant_valid && cand_valid) begin
      grant_valid <= 1'b1;
      grant_vec   <= cand;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      i_mask <= 1'b1;
      x_mask <= 1'b1;
    end else if (take) begin
      i_mask <= 1'b1;
      if (grant_vec == NMI_VEC) x_mask <= 1'b1;
    end else if (int_ret) begin
      i_mask <= ret_i;
      x_mask <= ret_x;
    end else begin
      if (set_i)      i_mask <= 1'b1;
      else if (clr_i) i_mask <= 1'b0;
      if (clr_x)      x_mask <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      prio_sel <= '0;
    else if (prio_wr && i_mask && prio_wdata < VW'(NSRC))
      prio_sel <= prio_wdata;
endmodule

module irq_prio_arbiter_chk #(
  parameter int NSRC = 15,
  parameter int VW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            int_ack,
  input logic            int_ret,
  input logic            prio_wr,
  input logic            grant_valid,
  input logic [VW-1:0]   grant_vec,
  input logic            i_mask,
  input logic            x_mask,
  input logic [VW-1:0]   prio_sel
);
  localparam logic [VW-1:0] NMI_VEC = VW'(NSRC);

  a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !int_ack) |=> (grant_valid && $stable(grant_vec)));

  a_r6_ack_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && int_ack) |=> (i_mask && !grant_valid));

  a_r5_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && grant_vec != NMI_VEC) |-> $past(!i_mask));

  a_r7_no_blocked_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && grant_vec == NMI_VEC) |-> $past(!x_mask));

  a_r8_x_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_mask) |-> ($past(int_ret) || $past(int_ack && grant_valid && grant_vec == NMI_VEC)));

  a_r4_prio_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prio_sel) |-> $past(prio_wr && i_mask));

  a_r3_prio_range: assert property (@(posedge clk) disable iff (!rst_n)
    prio_sel < NMI_VEC);
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NSRC(NSRC), .VW(VW)) u_chk (.*);

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_n = 1'b1, irq_edge_mode = 1'b0;
  logic [13:0] periph_req = '0;
  logic        nmi_req = 1'b0, set_i = 1'b0, clr_i = 1'b0, clr_x = 1'b0;
  logic        int_ack = 1'b0, int_ret = 1'b0, ret_x = 1'b0, ret_i = 1'b0;
  logic        prio_wr = 1'b0;
  logic [3:0]  prio_wdata = '0;
  logic        grant_valid, i_mask, x_mask;
  logic [3:0]  grant_vec, prio_sel;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_arbiter dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input logic [14:0] v);
    irq_n = ~v[0];
    periph_req = v[14:1];
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic write_prio(input logic [3:0] v);
    prio_wdata = v; pulse(prio_wr);
  endtask

  // Expects i_mask=1 and quiet inputs on entry; leaves i_mask=1.
  task automatic grant_cycle(input logic [14:0] v, input int exp, input string tag);
    set_src(v); wait_n(3);
    pulse(clr_i); wait_n(2);
    chk({tag, " valid"}, grant_valid, 1);
    chk({tag, " vec"}, grant_vec, exp);
    pulse(int_ack);
    chk({tag, " R6 ack clears"}, grant_valid, 0);
    chk({tag, " R6 ack sets I"}, i_mask, 1);
    set_src('0); wait_n(3);
  endtask

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(1);
    chk("R1 i_mask", i_mask, 1);
    chk("R1 x_mask", x_mask, 1);
    chk("R1 prio_sel", prio_sel, 0);
    chk("R1 grant_valid", grant_valid, 0);

    // R5 masking with pending requests
    set_src('1); wait_n(6);
    chk("R5 masked no grant", grant_valid, 0);
    pulse(clr_i); wait_n(1);
    chk("R5 pending granted after clear", grant_valid, 1);
    chk("R5 vec", grant_vec, 0);
    set_src('0); wait_n(4);
    chk("R6 held after drop", grant_valid, 1);
    chk("R6 vec stable", grant_vec, 0);
    pulse(int_ack); wait_n(3);

    // R12 latency: clear I first, then raise a request
    pulse(clr_i);
    set_src(15'h0100); wait_n(4);
    chk("R12 within four edges", grant_valid, 1);
    chk("R12 vec", grant_vec, 8);
    pulse(int_ack); set_src('0); wait_n(3);

    // R5 set beats clear
    set_i = 1'b1; clr_i = 1'b1; @(negedge clk); set_i = 1'b0; clr_i = 1'b0;
    chk("R5 set over clear", i_mask, 1);

    // R2 singles and all pairs
    for (int a = 0; a < 15; a++) grant_cycle(15'(1) << a, a, "R2 single");
    for (int a = 0; a < 15; a++)
      for (int b = a + 1; b < 15; b++)
        grant_cycle((15'(1) << a) | (15'(1) << b), a, "R2 pair");

    // R3 promotion sweep
    for (int p = 0; p < 15; p++) begin
      write_prio(4'(p));
      chk("R4 write with I set", prio_sel, p);
      grant_cycle('1, p, "R3 promoted wins");
      grant_cycle(15'h7fff & ~(15'(1) << p), (p == 0) ? 1 : 0, "R3 promoted absent");
    end
    write_prio(4'd0);

    // R4 ignored writes
    write_prio(4'd9);
    pulse(clr_i);
    write_prio(4'd5);
    chk("R4 ignored with I clear", prio_sel, 9);
    pulse(set_i);
    write_prio(4'd15);
    chk("R4 out of range ignored", prio_sel, 9);
    write_prio(4'd0);

    // R7 NMI blocked while X set
    nmi_req = 1'b1; set_src('1); wait_n(3);
    pulse(clr_i); wait_n(2);
    chk("R7 nmi blocked by X", grant_vec, 0);
    pulse(int_ack);
    chk("R7 X unchanged by maskable ack", x_mask, 1);
    wait_n(3);
    pulse(clr_x);
    chk("R8 clr_x clears", x_mask, 0);
    wait_n(1);
    chk("R7 nmi granted with I set", grant_valid, 1);
    chk("R7 nmi vec", grant_vec, 15);
    pulse(int_ack);
    chk("R7 ack sets X", x_mask, 1);
    chk("R7 ack sets I", i_mask, 1);
    nmi_req = 1'b0; set_src('0); wait_n(3);

    // R7 nmi outranks promoted maskable
    write_prio(4'd3);
    pulse(clr_i);
    pulse(clr_x);
    set_src('1); nmi_req = 1'b1; wait_n(4);
    chk("R7 nmi over maskable", grant_vec, 15);
    pulse(int_ack); nmi_req = 1'b0; set_src('0); wait_n(3);
    write_prio(4'd0);

    // R8 no software set path
    pulse(clr_x);
    pulse(set_i); pulse(clr_i); pulse(set_i);
    chk("R8 X stays clear", x_mask, 0);

    // R9 restore
    ret_x = 1'b1; ret_i = 1'b0; pulse(int_ret);
    chk("R9 restore X", x_mask, 1);
    chk("R9 restore I", i_mask, 0);
    ret_x = 1'b0; ret_i = 1'b1;
    int_ret = 1'b1; clr_i = 1'b1; @(negedge clk); int_ret = 1'b0; clr_i = 1'b0;
    chk("R9 restore X low", x_mask, 0);
    chk("R9 restore beats clr_i", i_mask, 1);
    ret_x = 1'b1; pulse(int_ret);

    // R10 level mode regrant
    irq_n = 1'b0; pulse(clr_i); wait_n(4);
    chk("R10 level grant", grant_vec, 0);
    pulse(int_ack); wait_n(2);
    pulse(clr_i); wait_n(2);
    chk("R10 regrant while low", grant_valid, 1);
    pulse(int_ack); irq_n = 1'b1; wait_n(3);

    // R11 edge mode
    irq_edge_mode = 1'b1; pulse(clr_i);
    irq_n = 1'b0; wait_n(3); irq_n = 1'b1; wait_n(3);
    chk("R11 edge latched", grant_valid, 1);
    chk("R11 edge vec", grant_vec, 0);
    pulse(int_ack); wait_n(2);
    pulse(clr_i); wait_n(4);
    chk("R11 one grant per edge", grant_valid, 0);
    irq_n = 1'b0; wait_n(5);
    chk("R11 new edge", grant_valid, 1);
    pulse(int_ack); wait_n(2);
    pulse(clr_i); wait_n(4);
    chk("R11 held low no regrant", grant_valid, 0);
    irq_n = 1'b1; irq_edge_mode = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule